// File: doc/BRIEF.md
# Prescaled Timebase Counter

This block keeps a 33-bit running count of time derived from a fixed 24 MHz reference clock. A 12-bit prescaler counts reference cycles. When the next prescaler value reaches or passes a programmable divisor, the main counter steps by one and the prescaler restarts from zero. Software sets the divisor and the run state, and reads or loads the count, through a plain register port. That port has a write strobe, a read strobe and a 2-bit word address.

The count is wider than the data bus. Software therefore reads it as two words. Reading the low word also captures the top bit into a shadow. A later read of the high word returns that captured bit, so both halves belong to the same instant. The divisor can be rewritten while the block is counting. The comparison is greater-or-equal, so a smaller divisor ends the current interval on the next enabled cycle.

Top module: `tick_timebase`

## Requirements
- R1: After reset, the count is zero, counting is disabled (control bit 0 reads 0), the divisor reads 0 and the high-word shadow reads 0.
- R2: While enabled and with a divisor N from 1 to 4095, the count steps by exactly one every N reference cycles. The prescaler restarts from zero on each step.
- R3: A divisor of 0 behaves as 1: the count steps on every enabled cycle.
- R4: A step happens on any enabled cycle where the prescaler plus one is at least the divisor. After the divisor is lowered below the current prescaler value, the step comes on the next enabled cycle instead of waiting for a 4096-cycle wrap.
- R5: Raising the divisor during an interval does not clear the prescaler. The current interval simply runs on until the prescaler reaches the new value.
- R6: The count goes from 0x1_FFFF_FFFF back to 0 and carries on counting.
- R7: A read at word address 2 returns count bits 31:0 and copies count bit 32 into a shadow. A read at word address 3 returns that shadow in bit 0 and zero elsewhere, never the live bit.
- R8: A write to address 2 loads count bits 31:0. A write to address 3 loads count bit 32 from data bit 0. Either load clears the prescaler and takes priority over a step in the same cycle.
- R9: Address 0 bit 0 is the enable. While it is 0, neither the prescaler nor the count changes unless a load occurs.
- R10: Address 1 bits 11:0 hold the divisor. Addresses 0 and 1 read back what was last written to them, with unused bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 24 MHz reference clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Write strobe, one cycle per write |
| regRdEn | input | 1 | Read strobe; a low-word read captures the shadow at the clock edge |
| regAddr | input | 2 | Word address: 0 control, 1 divisor, 2 count low, 3 count high |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for regAddr, valid in the same cycle |

## Verification
A prescaler stuck at the wrong value shows up as a step that comes too early or too late. The count read after a known number of cycles is then off by one, within one divisor period of the fault. A missed prescaler clear on load, or a prescaler that ran while disabled, moves the first step after re-enable or reload. The reads around those points are therefore placed exactly on the expected step edge. A shadow that follows the live bit shows up in the first high-word read taken after the low word wraps.

// File: rtl/tick_timebase_pkg.sv
package tick_timebase_pkg;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_DIV  = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_LO   = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_HI   = 2'd3;

  typedef struct packed {
    logic wrCtrl;
    logic wrDiv;
    logic loadLo;
    logic loadHi;
    logic latchShadow;
  } strobes_t;
endpackage

// File: rtl/tick_timebase_ctrl.sv
module tick_timebase_ctrl
  import tick_timebase_pkg::*;
#(
  parameter int PRESC_W = 12,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic               regRdEn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [DATA_W-1:0]  regWrData,
  output strobes_t           strobes,
  output logic               enable,
  output logic [PRESC_W-1:0] divisor
);
  always_comb begin
    strobes             = '0;
    strobes.wrCtrl      = regWrEn && (regAddr == ADDR_CTRL);
    strobes.wrDiv       = regWrEn && (regAddr == ADDR_DIV);
    strobes.loadLo      = regWrEn && (regAddr == ADDR_LO);
    strobes.loadHi      = regWrEn && (regAddr == ADDR_HI);
    strobes.latchShadow = regRdEn && (regAddr == ADDR_LO);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enable  <= 1'b0;
      divisor <= '0;
    end else begin
      if (strobes.wrCtrl) enable  <= regWrData[0];
      if (strobes.wrDiv)  divisor <= regWrData[PRESC_W-1:0];
    end
  end

  AST_ONE_WRITE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.wrCtrl, strobes.wrDiv, strobes.loadLo, strobes.loadHi})); // R10
  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.wrCtrl |=> $stable(enable)); // R9
  AST_DIV_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.wrDiv |=> $stable(divisor)); // R10
endmodule

// File: rtl/tick_timebase_dp.sv
module tick_timebase_dp
  import tick_timebase_pkg::*;
#(
  parameter int PRESC_W = 12,
  parameter int CNT_W   = 33,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobes_t           strobes,
  input  logic               enable,
  input  logic [PRESC_W-1:0] divisor,
  input  logic [DATA_W-1:0]  regWrData,
  output logic [CNT_W-1:0]   count,
  output logic [CNT_W-DATA_W-1:0] shadowHi
);
  localparam int HI_W = CNT_W - DATA_W;

  logic [PRESC_W-1:0] presc;
  logic [PRESC_W-1:0] effDiv;
  logic [PRESC_W:0]   prescNext;
  logic               step;
  logic               anyLoad;

  assign effDiv    = (divisor == '0) ? PRESC_W'(1) : divisor;
  assign prescNext = {1'b0, presc} + (PRESC_W+1)'(1);
  assign step      = enable && (prescNext >= {1'b0, effDiv});
  assign anyLoad   = strobes.loadLo || strobes.loadHi;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      presc <= '0;
    end else if (anyLoad) begin
      presc <= '0;
    end else if (enable) begin
      presc <= step ? '0 : prescNext[PRESC_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
    end else if (anyLoad) begin
      if (strobes.loadLo) count[DATA_W-1:0]     <= regWrData;
      if (strobes.loadHi) count[CNT_W-1:DATA_W] <= regWrData[HI_W-1:0];
    end else if (step) begin
      count <= count + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shadowHi <= '0;
    else if (strobes.latchShadow) shadowHi <= count[CNT_W-1:DATA_W];
  end

  AST_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    (!enable && !anyLoad) |=> ($stable(count) && $stable(presc))); // R9
  AST_LOAD_CLEARS_PRESC: assert property (@(posedge clk) disable iff (!rstN)
    anyLoad |=> (presc == '0)); // R8
  AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !anyLoad) |=> ((count == $past(count)) || (count == $past(count) + CNT_W'(1)))); // R2
  AST_STEP_RESTARTS: assert property (@(posedge clk) disable iff (!rstN)
    (!anyLoad && $changed(count)) |-> (presc == '0)); // R2
  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.latchShadow |=> $stable(shadowHi)); // R7
endmodule

// File: rtl/tick_timebase.sv
module tick_timebase
  import tick_timebase_pkg::*;
#(
  parameter int PRESC_W = 12,
  parameter int CNT_W   = 33,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [1:0]        regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData
);
  localparam int HI_W = CNT_W - DATA_W;

  strobes_t           strobes;
  logic               enable;
  logic [PRESC_W-1:0] divisor;
  logic [CNT_W-1:0]   count;
  logic [HI_W-1:0]    shadowHi;

  tick_timebase_ctrl #(.PRESC_W(PRESC_W), .DATA_W(DATA_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .strobes(strobes),
    .enable(enable), .divisor(divisor)
  );

  tick_timebase_dp #(.PRESC_W(PRESC_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .enable(enable),
    .divisor(divisor), .regWrData(regWrData), .count(count), .shadowHi(shadowHi)
  );

  always_comb begin
    unique case (regAddr)
      ADDR_CTRL: regRdData = {{(DATA_W-1){1'b0}}, enable};
      ADDR_DIV:  regRdData = {{(DATA_W-PRESC_W){1'b0}}, divisor};
      ADDR_LO:   regRdData = count[DATA_W-1:0];
      default:   regRdData = {{(DATA_W-HI_W){1'b0}}, shadowHi};
    endcase
  end
endmodule

// File: tb/tick_timebase_tb_top.sv
module tick_timebase_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic        regRdEn = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  int total = 0;
  int bad = 0;
  bit finished = 0;

  localparam logic [1:0] A_CTRL = 2'd0, A_DIV = 2'd1, A_LO = 2'd2, A_HI = 2'd3;

  tick_timebase dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData)
  );

  always #10 clk = ~clk;

  task automatic wrReg(input logic [1:0] a, input logic [31:0] d);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic rdCheck(input logic [1:0] a, input logic [31:0] exp, input string req);
    regAddr = a; regRdEn = 1'b1;
    #2;
    total++;
    if (regRdData !== exp) begin
      bad++;
      $display("FAIL %s addr=%0d actual=%h expected=%h", req, a, regRdData, exp);
    end
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic restart(input logic [31:0] div);
    wrReg(A_DIV, div);
    wrReg(A_CTRL, 32'd1);
    wrReg(A_HI, 32'd0);
    wrReg(A_LO, 32'd0);
  endtask

  task automatic testReset();
    rdCheck(A_CTRL, 32'd0, "R1");
    rdCheck(A_DIV, 32'd0, "R1");
    rdCheck(A_LO, 32'd0, "R1");
    rdCheck(A_HI, 32'd0, "R1");
  endtask

  task automatic testSpacing(input int n, input int k);
    restart(n);
    repeat (k) @(negedge clk);
    rdCheck(A_LO, k / n, "R2");
  endtask

  task automatic testMaxDiv();
    restart(4095);
    repeat (4094) @(negedge clk);
    rdCheck(A_LO, 32'd0, "R2");
    rdCheck(A_LO, 32'd1, "R2");
  endtask

  task automatic testZeroDiv();
    restart(0);
    repeat (5) @(negedge clk);
    rdCheck(A_LO, 32'd5, "R3");
  endtask

  task automatic testLowerDiv();
    restart(10);
    repeat (7) @(negedge clk);
    wrReg(A_DIV, 32'd3);
    rdCheck(A_LO, 32'd0, "R4");
    rdCheck(A_LO, 32'd1, "R4");
    repeat (2) @(negedge clk);
    rdCheck(A_LO, 32'd2, "R4");
  endtask

  task automatic testRaiseDiv();
    restart(4);
    repeat (2) @(negedge clk);
    wrReg(A_DIV, 32'd6);
    rdCheck(A_LO, 32'd0, "R5");
    rdCheck(A_LO, 32'd0, "R5");
    rdCheck(A_LO, 32'd0, "R5");
    rdCheck(A_LO, 32'd1, "R5");
  endtask

  task automatic testWrap();
    wrReg(A_DIV, 32'd1);
    wrReg(A_CTRL, 32'd1);
    wrReg(A_LO, 32'hFFFF_FFFF);
    wrReg(A_HI, 32'd1);
    rdCheck(A_LO, 32'hFFFF_FFFF, "R8");
    rdCheck(A_HI, 32'd1, "R6");
    rdCheck(A_LO, 32'd1, "R6");
    rdCheck(A_HI, 32'd0, "R6");
  endtask

  task automatic testShadow();
    wrReg(A_DIV, 32'd1);
    wrReg(A_HI, 32'd0);
    wrReg(A_LO, 32'hFFFF_FFFE);
    rdCheck(A_LO, 32'hFFFF_FFFE, "R7");
    rdCheck(A_LO, 32'hFFFF_FFFF, "R7");
    rdCheck(A_HI, 32'd0, "R7");
    rdCheck(A_LO, 32'd1, "R7");
    rdCheck(A_HI, 32'd1, "R7");
  endtask

  task automatic testFreeze();
    restart(5);
    repeat (3) @(negedge clk);
    wrReg(A_CTRL, 32'd0);
    repeat (50) @(negedge clk);
    rdCheck(A_CTRL, 32'd0, "R9");
    rdCheck(A_LO, 32'd0, "R9");
    wrReg(A_CTRL, 32'd1);
    rdCheck(A_LO, 32'd0, "R9");
    rdCheck(A_LO, 32'd1, "R9");
  endtask

  task automatic testLoadPriority();
    restart(1);
    repeat (4) @(negedge clk);
    wrReg(A_LO, 32'd100);
    rdCheck(A_LO, 32'd100, "R8");
    rdCheck(A_LO, 32'd101, "R8");
  endtask

  task automatic testReadback();
    wrReg(A_DIV, 32'hFFFF_F123);
    rdCheck(A_DIV, 32'h0000_0123, "R10");
    wrReg(A_CTRL, 32'hFFFF_FFFF);
    rdCheck(A_CTRL, 32'd1, "R10");
  endtask

  initial begin
    #(20 * 190000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testSpacing(1, 6);
    testSpacing(3, 10);
    testSpacing(7, 20);
    testMaxDiv();
    testZeroDiv();
    testLowerDiv();
    testRaiseDiv();
    testWrap();
    testShadow();
    testFreeze();
    testLoadPriority();
    testReadback();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule